// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a synchronous serial master that software drives through a small 32-bit register bus. Words written to the data register enter a transmit queue and have their width trimmed to the programmed frame size. A transfer engine takes them one at a time and sends each either through an SPI mode 0 shifter or around an internal loopback path. The word that comes back is trimmed to the same frame size and placed in a receive queue, where software reads it from the same data register.

The engine never overruns the receive queue. When that queue is full it leaves the transmit queue alone until software removes a received word. Fill-level status bits and two threshold interrupts, each set at half of the queue depth, let software pace itself without polling every word. A single level interrupt output is high while any unmasked raw interrupt bit is set. Identification bytes can be read near the top of the 4 KiB register window.

Top module: `spi_reg_master`

## Requirements
- R1: After reset both queues are empty and the interrupt mask is zero. Status (0x0C) reads 0x03, raw interrupts (0x18) read 0x08, masked interrupts (0x1C) read 0, the interrupt output is low and chip select (`cs_no`) is high.
- R2: Bits [3:0] of control 0 (0x00) set the frame size to field+1 bits. A word written to data (0x08) is trimmed to the size in force when it is written, and each received word is trimmed to the size in force when it is pushed.
- R3: Control 1 (0x04) bit 1 enables the engine. While it is clear, queued transmit words stay in the queue.
- R4: Status bit 0 is set when the transmit queue is empty, bit 1 when it is not full, bit 2 when the receive queue is not empty, bit 3 when the receive queue is full, and bit 4 (busy) while the transmit queue holds data.
- R5: Raw interrupt bit 2 is set when the receive queue holds 4 or more words, and bit 3 when the transmit queue holds 4 or fewer. The mask is at 0x14, the masked value (mask AND raw) is at 0x1C, and the interrupt output is high when that value is nonzero.
- R6: The engine moves a word only when the receive queue has room. When the receive queue is full, the transmit queue keeps its contents until a data read frees a slot. No received word is lost, and words arrive in the order they were written.
- R7: When control 1 bit 0 (loopback) is set, the received word equals the transmitted word. Otherwise it is the word sampled from `miso_i`.
- R8: Reading data with the receive queue empty returns 0. Writing data with the transmit queue full discards the write.
- R9: Word reads at 0xFE0 to 0xFFC return, in order, 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: No transfer takes place while control 1 bit 2 (slave select) is set or while the last value written to DMA control (0x20) is nonzero.
- R11: In serial mode, `cs_no` is low for the whole of each word and `sclk_o` idles low. Bits go out MSB first: `mosi_o` changes on the falling edge of `sclk_o`, and `miso_i` is sampled on the rising edge. Each `sclk_o` phase lasts max(prescaler, 2) clock cycles.
- R12: The prescaler (0x10) keeps and reads back 8 bits. DMA control reads 0. Writes to status and to the raw and masked interrupt registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address of the register access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; a read of the data register pops the receive queue |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |
| irq_o | output | 1 | Level interrupt |

## Verification
Software traffic and the engine can act on the same queue in the same cycle. The engine can pop the transmit queue in the cycle a new data write pushes it, and a loopback push can land in the receive queue in the cycle a data read pops it. The bench provokes both cases with back-to-back bus cycles in loopback mode. It judges them by the status value afterwards and by the word order the scoreboard sees, which must show no word lost or repeated. A second case is the receive queue becoming full while the transmit queue still holds words. Here the stalled words must come out after the earlier ones, and a discarded write on a full transmit queue must never appear.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_CTL0 = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CTL1 = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_DATA = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_STAT = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_PRSC = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_IMSK = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_IRAW = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_IMSD = 12'h01C;
  localparam logic [ADDR_W-1:0] OFF_DMAC = 12'h020;

  typedef struct packed {
    logic out_dis;
    logic slave;
    logic en;
    logic loop;
  } ctl1_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h22;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned W      = 16,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned BITS_W = $clog2(W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [W-1:0]      word_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic [DIV_W-1:0]  half_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [W-1:0]      rx_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_no
);
  logic [W-1:0]      out_q, in_q;
  logic [BITS_W-1:0] left_q;
  logic [DIV_W-1:0]  div_q;
  logic              busy_q, sclk_q, done_q;
  logic              tick;

  assign tick   = busy_q && (div_q == '0);
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = in_q;
  assign sclk_o = sclk_q;
  assign mosi_o = busy_q && out_q[W-1];
  assign cs_no  = !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      in_q   <= '0;
      left_q <= '0;
      div_q  <= '0;
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        sclk_q <= 1'b0;
        out_q  <= word_i << (BITS_W'(W) - bits_i);
        in_q   <= '0;
        left_q <= bits_i;
        div_q  <= half_i - 1'b1;
      end else if (busy_q) begin
        div_q <= tick ? half_i - 1'b1 : div_q - 1'b1;
        if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            in_q   <= {in_q[W-2:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (left_q == BITS_W'(1)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              left_q <= left_q - 1'b1;
              out_q  <= out_q << 1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned DIV_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no,
  output logic              irq_o
);
  localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned SIZE_W = $clog2(DATA_W);
  localparam int unsigned BITS_W = SIZE_W + 1;
  localparam int unsigned THR    = FIFO_DEPTH / 2;

  logic [DATA_W-1:0] ctl0_q;
  ctl1_t             ctl1_q;
  logic [DIV_W-1:0]  prsc_q;
  logic [3:0]        imsk_q;
  logic              dma_q;

  logic [DATA_W-1:0] size_mask;
  logic [SIZE_W-1:0] size_fld;
  logic [DIV_W-1:0]  half;
  logic              data_wr, data_rd, id_hit;

  logic              tx_pop, tx_full, tx_empty;
  logic [DATA_W-1:0] tx_head;
  logic [CNT_W-1:0]  tx_cnt;
  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head, rx_in;
  logic [CNT_W-1:0]  rx_cnt;

  logic              eng_ok, go, lb_go, sh_start, sh_busy, sh_done;
  logic [DATA_W-1:0] sh_rx;
  logic [4:0]        stat;
  logic [3:0]        iraw;

  assign size_fld = ctl0_q[SIZE_W-1:0];
  assign data_wr  = wr_i && (addr_i == OFF_DATA);
  assign data_rd  = rd_i && (addr_i == OFF_DATA);
  assign id_hit   = (addr_i[ADDR_W-1:5] == '1) && (addr_i[1:0] == 2'b00);
  assign half     = (prsc_q < DIV_W'(2)) ? DIV_W'(2) : prsc_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign size_mask[i] = (SIZE_W'(i) <= size_fld);
  end

  // register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl0_q <= '0;
      ctl1_q <= '0;
      prsc_q <= '0;
      imsk_q <= '0;
      dma_q  <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        OFF_CTL0: ctl0_q <= wdata_i[DATA_W-1:0];
        OFF_CTL1: ctl1_q <= wdata_i[3:0];
        OFF_PRSC: prsc_q <= wdata_i[DIV_W-1:0];
        OFF_IMSK: imsk_q <= wdata_i[3:0];
        OFF_DMAC: dma_q  <= |wdata_i;
        default:  ;
      endcase
    end
  end

  spi_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (data_wr),
    .wdata_i (wdata_i[DATA_W-1:0] & size_mask),
    .pop_i   (tx_pop),
    .rdata_o (tx_head),
    .cnt_o   (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  // transfer engine: one word in flight, never pushes into a full rx queue
  assign eng_ok   = ctl1_q.en && !ctl1_q.slave && !dma_q;
  assign go       = eng_ok && !tx_empty && !rx_full && !sh_busy && !sh_done;
  assign lb_go    = go && ctl1_q.loop;
  assign sh_start = go && !ctl1_q.loop;
  assign tx_pop   = go;
  assign rx_push  = lb_go || sh_done;
  assign rx_in    = (lb_go ? tx_head : sh_rx) & size_mask;
  assign rx_pop   = data_rd && !rx_empty;

  spi_shifter #(.W(DATA_W), .DIV_W(DIV_W), .BITS_W(BITS_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .word_i  (tx_head),
    .bits_i  (BITS_W'(size_fld) + 1'b1),
    .half_i  (half),
    .miso_i  (miso_i),
    .busy_o  (sh_busy),
    .done_o  (sh_done),
    .rx_o    (sh_rx),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .cs_no   (cs_no)
  );

  spi_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .wdata_i (rx_in),
    .pop_i   (rx_pop),
    .rdata_o (rx_head),
    .cnt_o   (rx_cnt),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  assign stat  = {!tx_empty, rx_full, !rx_empty, !tx_full, tx_empty};
  assign iraw  = {tx_cnt <= CNT_W'(THR), rx_cnt >= CNT_W'(THR), 2'b00};
  assign irq_o = |(iraw & imsk_q);

  always_comb begin
    rdata_o = '0;
    if (id_hit) begin
      rdata_o[7:0] = id_byte(addr_i[4:2]);
    end else begin
      case (addr_i)
        OFF_CTL0: rdata_o[DATA_W-1:0] = ctl0_q;
        OFF_CTL1: rdata_o[3:0]        = ctl1_q;
        OFF_DATA: rdata_o[DATA_W-1:0] = rx_empty ? '0 : rx_head;
        OFF_STAT: rdata_o[4:0]        = stat;
        OFF_PRSC: rdata_o[DIV_W-1:0]  = prsc_q;
        OFF_IMSK: rdata_o[3:0]        = imsk_q;
        OFF_IRAW: rdata_o[3:0]        = iraw;
        OFF_IMSD: rdata_o[3:0]        = iraw & imsk_q;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_reg_chk.sv
module spi_reg_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_pop,
  input logic             rx_push,
  input logic             data_wr,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [3:0]       ctl1,
  input logic             dma,
  input logic [3:0]       imsk,
  input logic             irq_o,
  input logic             cs_no,
  input logic             sclk_o
);
  // R3
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop |-> ctl1[1]);

  // R10
  slave_dma_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop |-> (!ctl1[2] && !dma));

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push |-> (rx_cnt < CNT_W'(DEPTH)));

  // R8
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && tx_cnt == CNT_W'(DEPTH) && !tx_pop) |=> (tx_cnt == CNT_W'(DEPTH)));

  // R5
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((imsk[2] && rx_cnt >= CNT_W'(DEPTH / 2)) ||
              (imsk[3] && tx_cnt <= CNT_W'(DEPTH / 2))));

  // R11
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
endmodule

bind spi_reg_master spi_reg_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tx_pop  (tx_pop),
  .rx_push (rx_push),
  .data_wr (data_wr),
  .tx_cnt  (tx_cnt),
  .rx_cnt  (rx_cnt),
  .ctl1    (ctl1_q),
  .dma     (dma_q),
  .imsk    (imsk_q),
  .irq_o   (irq_o),
  .cs_no   (cs_no),
  .sclk_o  (sclk_o)
);

// File: tb/spi_reg_master_test.sv
module spi_reg_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, mosi, cs_n, irq;
  logic        miso = 1'b0;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int exp_q[$];

  logic [7:0]  s_pat = 8'h3C;
  int          s_idx = 0;
  logic [15:0] mosi_cap = '0;
  int          hi_run = 0, hi_last = 0;

  always #2 clk = ~clk;

  spi_reg_master uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n), .irq_o(irq)
  );

  // serial slave model
  always @(negedge cs_n) begin
    s_idx = 7;
    miso = s_pat[7];
    mosi_cap = '0;
  end
  always @(negedge sclk) if (!cs_n && s_idx > 0) begin
    s_idx = s_idx - 1;
    miso = s_pat[s_idx];
  end
  always @(posedge sclk) if (!cs_n) mosi_cap = {mosi_cap[14:0], mosi};
  always @(negedge clk) begin
    if (sclk) hi_run = hi_run + 1;
    else if (hi_run > 0) begin hi_last = hi_run; hi_run = 0; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    check(req, v, exp);
  endtask

  // driver: push a word and its expected echo
  task automatic send(input logic [31:0] d, input logic [31:0] echo);
    bus_wr(12'h008, d);
    exp_q.push_back(echo);
  endtask

  // monitor: pop the receive queue and compare with the scoreboard
  task automatic take(input string req);
    logic [31:0] v;
    bus_rd(12'h008, v);
    if (exp_q.size() == 0) check(req, v, 32'hDEAD_BEEF);
    else check(req, v, exp_q.pop_front());
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] ids [8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd_chk("R1 status", 12'h00C, 32'h03);
    rd_chk("R1 raw", 12'h018, 32'h08);
    rd_chk("R1 masked", 12'h01C, 32'h0);
    rd_chk("R1 mask", 12'h014, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 cs", {31'd0, cs_n}, 32'd1);

    // R9 identification
    for (int i = 0; i < 8; i++) rd_chk("R9 id", 12'hFE0 + 12'(4 * i), {24'd0, ids[i]});

    // R12 prescaler width, DMA readback, read-only writes
    bus_wr(12'h010, 32'h1FF);
    rd_chk("R12 prescaler", 12'h010, 32'hFF);
    bus_wr(12'h020, 32'h0);
    rd_chk("R12 dma", 12'h020, 32'h0);
    bus_wr(12'h00C, 32'hFF);
    bus_wr(12'h018, 32'hFF);
    rd_chk("R12 status ro", 12'h00C, 32'h03);
    rd_chk("R12 raw ro", 12'h018, 32'h08);

    // R8 empty read
    rd_chk("R8 empty read", 12'h008, 32'h0);

    // R3/R4 disabled queueing, full-queue drop
    bus_wr(12'h000, 32'hF);
    bus_wr(12'h004, 32'h1);
    for (int i = 1; i <= 5; i++) send(32'h1111 * i, 32'h1111 * i);
    idle(4);
    rd_chk("R3 R4 held status", 12'h00C, 32'h12);
    rd_chk("R5 raw tx5", 12'h018, 32'h0);
    for (int i = 6; i <= 8; i++) send(32'h1111 * i, 32'h1111 * i);
    rd_chk("R4 tx full status", 12'h00C, 32'h10);
    bus_wr(12'h008, 32'h9999);
    bus_wr(12'h004, 32'h3);
    idle(12);
    rd_chk("R4 R6 rx full status", 12'h00C, 32'h0F);
    rd_chk("R5 raw both", 12'h018, 32'h0C);

    // R6 stall with receive queue full
    send(32'hAAAA, 32'hAAAA);
    send(32'hBBBB, 32'hBBBB);
    idle(4);
    rd_chk("R6 stalled status", 12'h00C, 32'h1E);
    for (int i = 0; i < 10; i++) begin
      take("R6 R8 order");
      idle(2);
    end
    rd_chk("R6 drained", 12'h00C, 32'h03);

    // R5 interrupt output
    bus_wr(12'h014, 32'h8);
    idle(1);
    check("R5 irq tx", {31'd0, irq}, 32'd1);
    rd_chk("R5 masked", 12'h01C, 32'h08);
    bus_wr(12'h014, 32'h4);
    idle(1);
    check("R5 irq masked off", {31'd0, irq}, 32'd0);
    for (int i = 0; i < 4; i++) send(32'h40 + i, 32'h40 + i);
    idle(4);
    check("R5 irq rx4", {31'd0, irq}, 32'd1);
    take("R5 drain");
    idle(1);
    check("R5 irq rx3", {31'd0, irq}, 32'd0);
    for (int i = 0; i < 3; i++) take("R5 drain");
    bus_wr(12'h014, 32'h0);

    // same-cycle push/pop on both queues
    send(32'h0101, 32'h0101);
    send(32'h0202, 32'h0202);
    send(32'h0303, 32'h0303);
    idle(3);
    send(32'h0404, 32'h0404);
    take("R6 collide");
    idle(3);
    rd_chk("R4 collide status", 12'h00C, 32'h07);
    for (int i = 0; i < 3; i++) take("R6 collide");

    // R2 frame size on write and on receive
    bus_wr(12'h000, 32'h3);
    send(32'hFF, 32'hF);
    idle(3);
    take("R2 write trim");
    bus_wr(12'h000, 32'hF);
    bus_wr(12'h004, 32'h1);
    bus_wr(12'h008, 32'hABCD);
    bus_wr(12'h000, 32'h7);
    bus_wr(12'h004, 32'h3);
    exp_q.push_back(32'hCD);
    idle(3);
    take("R2 receive trim");

    // R10 slave mode and DMA block the engine
    bus_wr(12'h004, 32'h7);
    send(32'h5A, 32'h5A);
    idle(5);
    rd_chk("R10 slave hold", 12'h00C, 32'h12);
    bus_wr(12'h020, 32'h1);
    bus_wr(12'h004, 32'h3);
    idle(5);
    rd_chk("R10 dma hold", 12'h00C, 32'h12);
    rd_chk("R12 dma reads zero", 12'h020, 32'h0);
    bus_wr(12'h020, 32'h0);
    idle(3);
    take("R10 release");

    // R7/R11 serial mode
    bus_wr(12'h010, 32'h3);
    bus_wr(12'h004, 32'h2);
    bus_wr(12'h008, 32'h1A5);
    exp_q.push_back(32'h3C);
    idle(5);
    check("R11 cs low", {31'd0, cs_n}, 32'd0);
    idle(80);
    check("R11 cs high", {31'd0, cs_n}, 32'd1);
    check("R11 mosi msb first", {24'd0, mosi_cap[7:0]}, 32'hA5);
    check("R11 sclk phase", hi_last, 32'd3);
    take("R7 serial rx");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule